// File: doc/BRIEF.md
# Serial Interrupt Slave Frame Engine

This block sits on the peripheral side of a single-wire, clocked, open-drain serial interrupt bus. It watches the sampled line level for a start pulse. When the pulse ends, it counts three-clock data frames from that rising edge. In each local request's own frame it pulls the line low if that request is asserted (low). In the clock after a low it drives the line high to restore it. In the third clock it releases the line.

The block also measures how long each stop pulse stays low, and uses that width to set the mode of the next cycle. In continuous mode only the host starts cycles. In quiet mode the block may begin a cycle itself, by pulling the idle line low for one clock, whenever its request levels differ from those it last reported. Request levels are synchronized to the bus clock and frozen at each start pulse's rising edge, so every cycle reports one consistent snapshot.

Top module: `sirq_slave`

## Requirements
- R1: During and after reset all three outputs are inactive, and the block comes up in continuous mode. It therefore never starts a cycle on its own until a short stop pulse has been seen.
- R2: Counting the first bus clock after the start pulse's rising edge as clock 1, frame N (N = 1..16) has its sample clock at clock 3N−1. At that clock `drv_lo` is high exactly when the level captured for that frame's slot is low.
- R3: At clock 3N `drv_hi` is high exactly when `drv_lo` was high in the sample clock just before. `drv_lo` and `drv_hi` are never high together.
- R4: At clock 3N+1 (turn-around) both drive enables are low. `oe` is high exactly when one of the drive enables is high.
- R5: The slot map is as follows. Frame 1 is never driven. Frame 2 carries `irq_lvl[1]`. Frame 3 is low when either `smi_lvl` or `irq_lvl[2]` is low. Frames 4 to 16 carry `irq_lvl[3]` to `irq_lvl[15]` in ascending order, so request 5 is sampled at clock 17. All request inputs are active low.
- R6: Request levels pass through a two-stage synchronizer and are captured once, at the start pulse's rising edge. A change during a cycle does not alter that cycle's slots.
- R7: From the rising edge until the stop pulse, the line level is ignored, so a low excursion during the frames does not disturb the count. After clock 49 nothing is driven.
- R8: A stop pulse that is low for 3 or more clocks selects continuous mode. In continuous mode a changed request level never causes `drv_lo`.
- R9: A stop pulse that is low for 2 or fewer clocks selects quiet mode. In quiet mode, once the line has been high for two sampled clocks while idle and the slot levels differ from those last captured, `drv_lo` rises for exactly one clock and then the line is released.
- R10: A cycle that the block starts itself is framed and reported exactly like a cycle the host starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Sampled level of the shared serial interrupt line |
| irq_lvl | input | 15 | Local requests 1 to 15, active low, asynchronous |
| smi_lvl | input | 1 | System management request, active low, shares the frame-3 slot |
| drv_lo | output | 1 | Pull the line low this clock |
| drv_hi | output | 1 | Drive the line high this clock |
| oe | output | 1 | Output enable for the line pad; low means high impedance |

## Verification
A wrong frame counter appears at once as a drive pulse at the wrong clock offset. Every slot offset is compared clock by clock against the 3N−1 rule in each cycle. Wrong latching or synchronization shows up as a slot whose level follows an input that changed mid-cycle, within the same cycle. A wrong stop-width decision stays hidden until the idle window after that stop pulse. There it shows within two clocks, either as a missing one-clock self-start pulse in quiet mode or as an unwanted one in continuous mode.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SELF   = 2'd1,
        ST_FRAMES = 2'd2,
        ST_STOP   = 2'd3
    } sirq_state_t;

    typedef enum logic {
        MODE_CONT  = 1'b0,
        MODE_QUIET = 1'b1
    } sirq_mode_t;

    typedef struct packed {
        logic lo;
        logic hi;
    } sirq_drive_t;

    // Clock offset (from the start rising edge) of a frame's sample phase.
    function automatic int sample_clk(input int frame);
        return 3 * frame - 1;
    endfunction

endpackage

// File: rtl/sirq_sync.sv
module sirq_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '1;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/sirq_slot_map.sv
module sirq_slot_map #(
    parameter int NUM_FRAMES = 16
) (
    input  logic [NUM_FRAMES-1:1] irq,
    input  logic                  smi,
    output logic [NUM_FRAMES-1:0] slot
);
    // slot[n] is the active-low level reported in frame n+1
    for (genvar n = 0; n < NUM_FRAMES; n++) begin : g_slot
        if (n == 0) begin : g_rsvd
            assign slot[n] = 1'b1;
        end else if (n == 2) begin : g_shared
            assign slot[n] = irq[n] & smi;
        end else begin : g_plain
            assign slot[n] = irq[n];
        end
    end
endmodule

// File: rtl/sirq_frame_drv.sv
module sirq_frame_drv
    import sirq_pkg::*;
#(
    parameter int NUM_FRAMES = 16,
    parameter int CNT_W      = 6
) (
    input  logic                  active,
    input  logic [CNT_W-1:0]      cnt,
    input  logic [NUM_FRAMES-1:0] slot,
    output sirq_drive_t           drv
);
    logic [NUM_FRAMES-1:0] lo_hit;
    logic [NUM_FRAMES-1:0] hi_hit;

    for (genvar n = 0; n < NUM_FRAMES; n++) begin : g_frame
        localparam int SAMP = sample_clk(n + 1);
        assign lo_hit[n] = active && (cnt == CNT_W'(SAMP))     && !slot[n];
        assign hi_hit[n] = active && (cnt == CNT_W'(SAMP + 1)) && !slot[n];
    end

    always_comb begin
        drv.lo = |lo_hit;
        drv.hi = |hi_hit;
    end
endmodule

// File: rtl/sirq_slave.sv
module sirq_slave
    import sirq_pkg::*;
#(
    parameter int NUM_FRAMES  = 16,
    parameter int CONT_LOW    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  line_in,
    input  logic [NUM_FRAMES-1:1] irq_lvl,
    input  logic                  smi_lvl,
    output logic                  drv_lo,
    output logic                  drv_hi,
    output logic                  oe
);
    localparam int LAST_CNT = 3 * NUM_FRAMES + 1;
    localparam int CNT_W    = $clog2(LAST_CNT + 1);
    localparam int LOW_W    = $clog2(CONT_LOW + 1);

    sirq_state_t           state;
    sirq_mode_t            mode;
    logic [CNT_W-1:0]      cnt;
    logic [LOW_W-1:0]      low_cnt;
    logic                  line_prev;
    logic [NUM_FRAMES-1:0] slot_lat;
    logic [NUM_FRAMES-1:0] slot_now;
    logic [NUM_FRAMES-1:1] irq_s;
    logic                  smi_s;
    sirq_drive_t           fdrv;
    logic                  rise;
    logic                  changed;

    sirq_sync #(.W(NUM_FRAMES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({smi_lvl, irq_lvl}),
        .q   ({smi_s, irq_s})
    );

    sirq_slot_map #(.NUM_FRAMES(NUM_FRAMES)) u_map (
        .irq  (irq_s),
        .smi  (smi_s),
        .slot (slot_now)
    );

    sirq_frame_drv #(.NUM_FRAMES(NUM_FRAMES), .CNT_W(CNT_W)) u_drv (
        .active (state == ST_FRAMES),
        .cnt    (cnt),
        .slot   (slot_lat),
        .drv    (fdrv)
    );

    assign rise    = !line_prev && line_in;
    assign changed = (slot_now != slot_lat);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            mode      <= MODE_CONT;
            cnt       <= '0;
            low_cnt   <= '0;
            line_prev <= 1'b1;
            slot_lat  <= '1;
        end else begin
            line_prev <= line_in;
            case (state)
                ST_IDLE: begin
                    if (rise) begin
                        state    <= ST_FRAMES;
                        cnt      <= CNT_W'(1);
                        slot_lat <= slot_now;
                    end else if (mode == MODE_QUIET && changed && line_in && line_prev) begin
                        state <= ST_SELF;
                    end
                end
                ST_SELF: begin
                    state <= ST_IDLE;
                end
                ST_FRAMES: begin
                    if (cnt == CNT_W'(LAST_CNT)) begin
                        state   <= ST_STOP;
                        low_cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_STOP: begin
                    if (!line_in) begin
                        if (low_cnt != LOW_W'(CONT_LOW)) low_cnt <= low_cnt + LOW_W'(1);
                    end else if (low_cnt != '0) begin
                        mode  <= (low_cnt >= LOW_W'(CONT_LOW)) ? MODE_CONT : MODE_QUIET;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign drv_lo = fdrv.lo || (state == ST_SELF);
    assign drv_hi = fdrv.hi;
    assign oe     = drv_lo || drv_hi;
endmodule

// File: rtl/sirq_slave_chk.sv
module sirq_slave_chk (
    input logic clk,
    input logic rst,
    input logic drv_lo,
    input logic drv_hi,
    input logic oe
);
    // R3
    lo_hi_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(drv_lo && drv_hi));

    // R3
    hi_after_lo_chk: assert property (@(posedge clk) disable iff (rst)
        drv_hi |-> $past(drv_lo));

    // R4
    release_after_hi_chk: assert property (@(posedge clk) disable iff (rst)
        drv_hi |=> !oe);

    // R9
    single_low_chk: assert property (@(posedge clk) disable iff (rst)
        drv_lo |=> !drv_lo);

    // R4
    oe_when_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_lo || drv_hi) |-> oe);
endmodule

bind sirq_slave sirq_slave_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .drv_lo (drv_lo),
    .drv_hi (drv_hi),
    .oe     (oe)
);

// File: tb/sirq_slave_tb.sv
module sirq_slave_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_in = 1'b1;
    logic [15:1] irq = '1;
    logic        smi = 1'b1;
    logic        drv_lo, drv_hi, oe;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    sirq_slave u_dut (
        .clk(clk), .rst(rst), .line_in(line_in), .irq_lvl(irq),
        .smi_lvl(smi), .drv_lo(drv_lo), .drv_hi(drv_hi), .oe(oe)
    );

    // {smi, irq[15:1]}
    localparam logic [15:0] VEC [6] = '{
        16'hFFFF, 16'h0000, 16'h7FFF, 16'hFFFD, 16'hFFFE, 16'hBFEF
    };

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {oe,hi,lo} actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic slot_lvl(input int f, input logic [15:1] v, input logic s);
        if (f == 1) return 1'b1;
        if (f == 3) return v[2] & s;
        return v[f-1];
    endfunction

    function automatic logic [2:0] exp_out(input int j, input logic [15:1] v, input logic s);
        logic lo, hi;
        lo = 1'b0; hi = 1'b0;
        if (j % 3 == 2 && (j + 1) / 3 <= 16) lo = !slot_lvl((j + 1) / 3, v, s);
        if (j % 3 == 0 && j >= 3 && j / 3 <= 16) hi = !slot_lvl(j / 3, v, s);
        return {lo | hi, hi, lo};
    endfunction

    task automatic host_cycle(input logic [15:1] v, input logic s, input int start_len,
                              input int stop_len, input logic [15:1] mv, input logic ms,
                              input bit glitch, input string tag);
        @(negedge clk) line_in = 1'b0;
        repeat (start_len - 1) @(negedge clk);
        @(negedge clk) line_in = 1'b1;
        for (int j = 1; j <= 52; j++) begin
            @(negedge clk);
            chk(tag, {oe, drv_hi, drv_lo}, exp_out(j, v, s));
            if (j == 10) begin irq = mv; smi = ms; end
            if (glitch && j == 20) line_in = 1'b0;
            if (glitch && j == 22) line_in = 1'b1;
        end
        line_in = 1'b0;
        repeat (stop_len - 1) @(negedge clk);
        @(negedge clk) line_in = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", {oe, drv_hi, drv_lo}, 3'b000);
        rst = 1'b0;
        // R1: continuous after reset, a change must not self-start
        irq[5] = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R1 no self start", {oe, drv_hi, drv_lo}, 3'b000);
        end

        // R2 R3 R4 R5: table of request patterns, host started, continuous stops
        for (int i = 0; i < 6; i++) begin
            irq = VEC[i][14:0];
            smi = VEC[i][15];
            repeat (3) @(negedge clk);
            host_cycle(VEC[i][14:0], VEC[i][15], 4, 3, VEC[i][14:0], VEC[i][15], 1'b0,
                       "R2 R3 R4 R5");
        end

        // R6 R7: mid-cycle change and line glitch ignored; short stop -> quiet
        irq = 15'h7FEF; smi = 1'b1;
        repeat (3) @(negedge clk);
        host_cycle(15'h7FEF, 1'b1, 5, 2, 15'h7F7E, 1'b0, 1'b1, "R6 R7");

        // R9: quiet mode self start, one clock low then release
        @(negedge clk);
        chk("R9 idle before self start", {oe, drv_hi, drv_lo}, 3'b000);
        @(negedge clk);
        chk("R9 self start low", {oe, drv_hi, drv_lo}, 3'b101);
        line_in = 1'b0;
        @(negedge clk);
        chk("R9 self start released", {oe, drv_hi, drv_lo}, 3'b000);

        // R10: the self-started cycle reports the new levels; long stop -> continuous
        host_cycle(15'h7F7E, 1'b0, 1, 3, 15'h7F7E, 1'b0, 1'b0, "R10");

        // R8: continuous mode, changed levels never start a cycle
        irq = 15'h0F0F; smi = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk("R8 no self start", {oe, drv_hi, drv_lo}, 3'b000);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule